// File: doc/BRIEF.md
# Interrupt control and status register for a four-port digital I/O card

This block is the card-level control/status register of a digital I/O card with four ports. It holds a soft-reset bit, a bank-select bit that steers a shared port register window either to ports 0/1 or to ports 2/3, and two interrupt enables. It merges two kinds of interrupt source onto one active-high interrupt line. The first kind is edge events, taken as per-port pending levels that the port logic has already qualified. The second kind is data-available events, taken as per-port set pulses that are held here until software reads that port.

Each kind has a sticky status flag. A flag sets on a rising edge of the OR of its sources. It stays set until an interrupt-acknowledge cycle, which returns both flags in a status word and clears them. A flag sets again only when its OR has fallen to zero and then risen once more. A source that is still held after an acknowledge does not set it again. A flag with its enable off can still be polled, but it never drives the interrupt line.

Top module: `dio_irq_csr`

## Requirements
- R1: After hardware reset, the read word, the acknowledge word, soft reset, bank select and the interrupt line are all 0.
- R2: A register write loads soft reset from bit 0, bank select from bit 4, the edge enable from bit 5 and the data-available enable from bit 6. Each of these bits reads back at the same position, and soft_rst_o and bank_sel_o follow bits 0 and 4 from the cycle after the write.
- R3: Writes to every other bit have no effect. Status bits 8 and 9 cannot be written, and every bit other than 0, 4, 5, 6, 8 and 9 reads as 0 (a write of FFFFh reads back 0071h when no flag is set).
- R4: Read bit 8, the edge flag, sets at the clock edge at which the OR of the edge pending inputs is 1 while it was 0 at the previous edge.
- R5: A dav_set_i pulse sets that port's data-available indication, and a port_rd_i strobe clears it. Read bit 9, the data-available flag, sets one clock edge after the OR of these indications rises, which is two edges after the pulse.
- R6: Both flags hold until an acknowledge. While iack_i is high, iack_word_o carries the edge flag in bit 8 and the data-available flag in bit 9, with all other bits 0. The flags clear at that clock edge.
- R7: After an acknowledge, a source OR that is still held does not set its flag again. The flag re-arms only on a new rising edge of that OR.
- R8: irq_o is registered from (bit 8 AND bit 5) OR (bit 9 AND bit 6). It rises one edge after that term becomes true, and it falls one edge after an acknowledge clears the flag.
- R9: With an enable bit at 0, its flag still sets and reads back, but irq_o stays low.
- R10: A rising edge of a source OR in the same cycle as an acknowledge leaves that flag set.
- R11: If dav_set_i and port_rd_i are high for the same port in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| csr_wr_i | input | 1 | Register write strobe |
| csr_wdata_i | input | 16 | Register write data |
| csr_rdata_o | output | 16 | Register read data (control bits and status flags) |
| iack_i | input | 1 | Interrupt-acknowledge cycle strobe |
| iack_word_o | output | 16 | Acknowledge response word (flags in bits 8 and 9) |
| edge_pend_i | input | 4 | Per-port qualified edge-pending levels |
| dav_set_i | input | 4 | Per-port data-became-available pulses |
| port_rd_i | input | 4 | Per-port read strobes that clear the data-available indication |
| soft_rst_o | output | 1 | Soft reset to the rest of the card |
| bank_sel_o | output | 1 | Port window bank select (0: ports 0/1, 1: ports 2/3) |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The checker watches these on every cycle: the zeros in the unused read bits, the match between the acknowledge word and the readback flags, how a write reaches soft reset and bank select, that the interrupt line equals the registered enable-and-flag term, that a flag holds until an acknowledge, and that an acknowledge with no edge source pending clears the edge flag. Several behaviours span many cycles or depend on order, so only the bench scenarios show them. These are re-arming after a held source, the lost-event rule when an edge and an acknowledge meet in the same cycle, the two-edge delay of the data-available path, set winning over a port read, and the exact cycle in which the interrupt line rises and falls.

// File: rtl/dio_irq_pkg.sv
package dio_irq_pkg;

    localparam int CSR_W        = 16;
    localparam int BIT_SRST     = 0;
    localparam int BIT_BANK     = 4;
    localparam int BIT_EN_EDGE  = 5;
    localparam int BIT_EN_DAV   = 6;
    localparam int BIT_FLG_EDGE = 8;
    localparam int BIT_FLG_DAV  = 9;

    // index of each interrupt kind in the flag vector
    localparam int KIND_EDGE = 0;
    localparam int KIND_DAV  = 1;
    localparam int NUM_KINDS = 2;

    typedef struct packed {
        logic srst;
        logic bank;
        logic en_edge;
        logic en_dav;
    } ctrl_t;

    typedef struct packed {
        logic flag;
        logic src_q;
    } sticky_t;

endpackage

// File: rtl/dio_csr_ctrl.sv
module dio_csr_ctrl
    import dio_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en_i,
    input  ctrl_t wr_val_i,
    output ctrl_t ctrl_o
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en_i) begin
            ctrl_d = wr_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

endmodule

// File: rtl/dio_dav_track.sv
module dio_dav_track #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] set_i,
    input  logic [NUM_PORTS-1:0] clr_i,
    output logic [NUM_PORTS-1:0] dav_o
);

    typedef struct packed {
        logic [NUM_PORTS-1:0] dav;
    } dav_state_t;

    dav_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PORTS; p++) begin
            // a new arrival outranks the read that would clear it
            if (set_i[p]) begin
                st_d.dav[p] = 1'b1;
            end else if (clr_i[p]) begin
                st_d.dav[p] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dav_o = st_q.dav;

endmodule

// File: rtl/dio_sticky_flag.sv
module dio_sticky_flag
    import dio_irq_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic             ack_i,
    output logic             flag_o
);

    sticky_t st_d, st_q;
    logic    any_src;
    logic    rise;

    always_comb begin
        any_src    = |src_i;
        rise       = any_src & ~st_q.src_q;
        st_d.src_q = any_src;
        // a rise in the acknowledge cycle keeps the flag so no event is lost
        st_d.flag  = rise | (st_q.flag & ~ack_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/dio_irq_csr.sv
module dio_irq_csr
    import dio_irq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = CSR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_wr_i,
    input  logic [DATA_W-1:0]    csr_wdata_i,
    output logic [DATA_W-1:0]    csr_rdata_o,
    input  logic                 iack_i,
    output logic [DATA_W-1:0]    iack_word_o,
    input  logic [NUM_PORTS-1:0] edge_pend_i,
    input  logic [NUM_PORTS-1:0] dav_set_i,
    input  logic [NUM_PORTS-1:0] port_rd_i,
    output logic                 soft_rst_o,
    output logic                 bank_sel_o,
    output logic                 irq_o
);

    localparam logic [DATA_W-1:0] WR_MASK =
        DATA_W'((1 << BIT_SRST) | (1 << BIT_BANK) | (1 << BIT_EN_EDGE) | (1 << BIT_EN_DAV));

    typedef struct packed {
        logic irq;
    } top_state_t;

    ctrl_t                                 wr_val;
    ctrl_t                                 ctrl;
    logic [NUM_PORTS-1:0]                  dav_lvl;
    logic [NUM_KINDS-1:0][NUM_PORTS-1:0]   kind_src;
    logic [NUM_KINDS-1:0]                  flags;
    logic                                  unused_wbits;
    top_state_t                            st_d, st_q;

    assign unused_wbits = ^(csr_wdata_i & ~WR_MASK);

    always_comb begin
        wr_val.srst    = csr_wdata_i[BIT_SRST];
        wr_val.bank    = csr_wdata_i[BIT_BANK];
        wr_val.en_edge = csr_wdata_i[BIT_EN_EDGE];
        wr_val.en_dav  = csr_wdata_i[BIT_EN_DAV];
    end

    dio_csr_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (csr_wr_i),
        .wr_val_i (wr_val),
        .ctrl_o   (ctrl)
    );

    dio_dav_track #(.NUM_PORTS(NUM_PORTS)) i_dav (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (dav_set_i),
        .clr_i (port_rd_i),
        .dav_o (dav_lvl)
    );

    assign kind_src[KIND_EDGE] = edge_pend_i;
    assign kind_src[KIND_DAV]  = dav_lvl;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        dio_sticky_flag #(.N_SRC(NUM_PORTS)) i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (kind_src[k]),
            .ack_i  (iack_i),
            .flag_o (flags[k])
        );
    end

    always_comb begin
        st_d.irq = (flags[KIND_EDGE] & ctrl.en_edge) | (flags[KIND_DAV] & ctrl.en_dav);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        csr_rdata_o               = '0;
        csr_rdata_o[BIT_SRST]     = ctrl.srst;
        csr_rdata_o[BIT_BANK]     = ctrl.bank;
        csr_rdata_o[BIT_EN_EDGE]  = ctrl.en_edge;
        csr_rdata_o[BIT_EN_DAV]   = ctrl.en_dav;
        csr_rdata_o[BIT_FLG_EDGE] = flags[KIND_EDGE];
        csr_rdata_o[BIT_FLG_DAV]  = flags[KIND_DAV];

        iack_word_o               = '0;
        iack_word_o[BIT_FLG_EDGE] = flags[KIND_EDGE];
        iack_word_o[BIT_FLG_DAV]  = flags[KIND_DAV];
    end

    assign soft_rst_o = ctrl.srst;
    assign bank_sel_o = ctrl.bank;
    assign irq_o      = st_q.irq;

endmodule

// File: rtl/dio_irq_csr_chk.sv
module dio_irq_csr_chk
    import dio_irq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = CSR_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 csr_wr_i,
    input logic                 wd_srst,
    input logic                 wd_bank,
    input logic [DATA_W-1:0]    csr_rdata_o,
    input logic                 iack_i,
    input logic [DATA_W-1:0]    iack_word_o,
    input logic [NUM_PORTS-1:0] edge_pend_i,
    input logic                 soft_rst_o,
    input logic                 bank_sel_o,
    input logic                 irq_o
);

    localparam logic [DATA_W-1:0] DEF_MASK =
        DATA_W'((1 << BIT_SRST) | (1 << BIT_BANK) | (1 << BIT_EN_EDGE) |
                (1 << BIT_EN_DAV) | (1 << BIT_FLG_EDGE) | (1 << BIT_FLG_DAV));
    localparam logic [DATA_W-1:0] FLG_MASK =
        DATA_W'((1 << BIT_FLG_EDGE) | (1 << BIT_FLG_DAV));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata_o & ~DEF_MASK) == '0);

    assert_iack_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iack_word_o == (csr_rdata_o & FLG_MASK));

    assert_write_ctrl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_i |=> (soft_rst_o == $past(wd_srst)) && (bank_sel_o == $past(wd_bank)));

    assert_irq_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past((csr_rdata_o[BIT_FLG_EDGE] & csr_rdata_o[BIT_EN_EDGE]) |
                                (csr_rdata_o[BIT_FLG_DAV]  & csr_rdata_o[BIT_EN_DAV])));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata_o[BIT_FLG_EDGE] && !iack_i) |=> csr_rdata_o[BIT_FLG_EDGE]);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_i && edge_pend_i == '0) |=> !csr_rdata_o[BIT_FLG_EDGE]);

endmodule

bind dio_irq_csr dio_irq_csr_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_wr_i    (csr_wr_i),
    .wd_srst     (csr_wdata_i[dio_irq_pkg::BIT_SRST]),
    .wd_bank     (csr_wdata_i[dio_irq_pkg::BIT_BANK]),
    .csr_rdata_o (csr_rdata_o),
    .iack_i      (iack_i),
    .iack_word_o (iack_word_o),
    .edge_pend_i (edge_pend_i),
    .soft_rst_o  (soft_rst_o),
    .bank_sel_o  (bank_sel_o),
    .irq_o       (irq_o)
);

// File: tb/test_dio_irq_csr.sv
module test_dio_irq_csr;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_wr = 1'b0;
    logic [15:0]   csr_wdata = '0;
    logic [15:0]   csr_rdata;
    logic          iack = 1'b0;
    logic [15:0]   iack_word;
    logic [NP-1:0] edge_pend = '0;
    logic [NP-1:0] dav_set = '0;
    logic [NP-1:0] port_rd = '0;
    logic          soft_rst;
    logic          bank_sel;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dio_irq_csr #(.NUM_PORTS(NP)) i_dio_irq_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_wr_i    (csr_wr),
        .csr_wdata_i (csr_wdata),
        .csr_rdata_o (csr_rdata),
        .iack_i      (iack),
        .iack_word_o (iack_word),
        .edge_pend_i (edge_pend),
        .dav_set_i   (dav_set),
        .port_rd_i   (port_rd),
        .soft_rst_o  (soft_rst),
        .bank_sel_o  (bank_sel),
        .irq_o       (irq)
    );

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic write_csr(input logic [15:0] v);
        csr_wr    = 1'b1;
        csr_wdata = v;
        step();
        csr_wr    = 1'b0;
        csr_wdata = '0;
    endtask

    task automatic t_reset();
        check("R1", "rdata", csr_rdata, 16'h0000);
        check("R1", "iack_word", iack_word, 16'h0000);
        check("R1", "outs", {13'd0, soft_rst, bank_sel, irq}, 16'h0000);
    endtask

    task automatic t_ctrl();
        write_csr(16'h0001);
        check("R2", "srst readback", csr_rdata, 16'h0001);
        check("R2", "soft_rst_o", {15'd0, soft_rst}, 16'h0001);
        write_csr(16'h0010);
        check("R2", "bank readback", csr_rdata, 16'h0010);
        check("R2", "bank/srst outs", {14'd0, soft_rst, bank_sel}, 16'h0001);
        write_csr(16'hFFFF);
        check("R3", "only defined bits", csr_rdata, 16'h0071);
        write_csr(16'h0000);
        check("R3", "cleared", csr_rdata, 16'h0000);
    endtask

    task automatic t_edge();
        // enables off: flag polls, no IRQ (R9)
        edge_pend[2] = 1'b1;
        step();
        check("R4", "edge flag set", csr_rdata, 16'h0100);
        step();
        check("R9", "irq masked", {15'd0, irq}, 16'h0000);
        iack = 1'b1;
        check("R6", "iack word edge", iack_word, 16'h0100);
        step();
        iack = 1'b0;
        check("R6", "flag cleared by ack", csr_rdata, 16'h0000);
        step(2);
        check("R7", "held source no re-arm", csr_rdata, 16'h0000);
        edge_pend = '0;
        step();
        edge_pend[1] = 1'b1;
        step();
        check("R7", "re-arm on new rise", csr_rdata, 16'h0100);
        // enable edge interrupts
        write_csr(16'h0020);
        check("R8", "irq one edge later (still 0)", {15'd0, irq}, 16'h0000);
        step();
        check("R8", "irq rises", {15'd0, irq}, 16'h0001);
        // R10: rise of source OR in the acknowledge cycle
        edge_pend = '0;
        step();
        edge_pend[0] = 1'b1;
        iack = 1'b1;
        step();
        iack = 1'b0;
        check("R10", "flag kept on same-cycle rise", csr_rdata, 16'h0120);
        iack = 1'b1;
        step();
        iack = 1'b0;
        check("R6", "flag cleared", csr_rdata, 16'h0020);
        check("R8", "irq still high one edge", {15'd0, irq}, 16'h0001);
        step();
        check("R8", "irq falls", {15'd0, irq}, 16'h0000);
        edge_pend = '0;
        write_csr(16'h0000);
    endtask

    task automatic t_dav();
        write_csr(16'h0040);
        dav_set[3] = 1'b1;
        step();
        dav_set = '0;
        check("R5", "flag not yet", csr_rdata, 16'h0040);
        step();
        check("R5", "dav flag set", csr_rdata, 16'h0240);
        check("R8", "irq not yet", {15'd0, irq}, 16'h0000);
        step();
        check("R8", "dav irq", {15'd0, irq}, 16'h0001);
        iack = 1'b1;
        check("R6", "iack word dav", iack_word, 16'h0200);
        step();
        iack = 1'b0;
        check("R7", "held dav no re-arm", csr_rdata, 16'h0040);
        step(2);
        check("R7", "still clear", csr_rdata, 16'h0040);
        port_rd[3] = 1'b1;
        step();
        port_rd = '0;
        dav_set[1] = 1'b1;
        step();
        dav_set = '0;
        step();
        check("R5", "re-arm after port read", csr_rdata, 16'h0240);
        iack = 1'b1;
        port_rd[1] = 1'b1;
        step();
        iack = 1'b0;
        port_rd = '0;
        check("R5", "cleared", csr_rdata, 16'h0040);
        dav_set[2] = 1'b1;
        port_rd[2] = 1'b1;
        step();
        dav_set = '0;
        port_rd = '0;
        step();
        check("R11", "set wins over read", csr_rdata, 16'h0240);
        write_csr(16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_ctrl();
        t_edge();
        t_dav();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule